// File: doc/BRIEF.md
# Trimmed-Mean Sample Averager

This block reduces a short burst of 12-bit unsigned conversion results to one filtered value. While the burst streams in, it keeps a running sum, the smallest sample and the largest sample. When the last sample has arrived, it subtracts one smallest and one largest value from the sum and divides the remainder by the number of samples left. Because it keeps only these running values, it needs no sample buffer.

A burst holds either 6 or 10 samples. After trimming, 4 or 8 samples remain, so the division is a right shift by 2 or 3 bits. A `start_i` pulse clears the running state and latches the burst length. Samples then arrive one per cycle, at any rate, qualified by `smp_valid_i`. One cycle after the final sample is accepted, the averaged value appears with a single-cycle `res_valid_o` pulse.

Control is a three-state machine:
- IDLE: waits for a start.
- COLLECT: accepts samples.
- EMIT: presents the result for one cycle.

The transitions are:
- IDLE to COLLECT on start.
- COLLECT to COLLECT on start (restart).
- COLLECT to EMIT on the final valid sample without start.
- EMIT to COLLECT on start.
- EMIT to IDLE otherwise.

Top module: `trim_avg`

## Requirements
- R1: After reset the block is in IDLE with `res_valid_o` = 0 and `res_data_o` = 0. Samples offered before any start produce no result.
- R2: `long_i` is sampled only in the start cycle. 0 selects a burst of 6 samples and 1 selects a burst of 10. Changing `long_i` during a burst has no effect.
- R3: The running sum is 16 bits wide, so ten samples of FFFh give a result of FFFh without overflow.
- R4: For a 6-sample burst, the result is (sum − max − min) >> 2, with the fraction truncated.
- R5: For a 10-sample burst, the result is (sum − max − min) >> 3, with the fraction truncated.
- R6: When several samples share the extreme value, only one instance is removed at the low end and one at the high end.
- R7: `res_valid_o` is high for exactly one cycle: the cycle after the clock edge that accepts the final sample. `res_data_o` is 0 whenever `res_valid_o` is low.
- R8: A start during COLLECT abandons the partial burst. The next result reflects only samples accepted after that start.
- R9: If start and a valid sample arrive in the same cycle, start wins. That sample is discarded, no result is produced, and a fresh burst begins.
- R10: Cycles with `smp_valid_i` low do not count. Samples offered in IDLE, or after a result without a new start, are ignored.
- R11: A start arriving in the EMIT cycle does not suppress the result being presented, and it opens a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the running state and begins a burst |
| long_i | input | 1 | Burst length select: 0 = 6 samples, 1 = 10 samples |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | 12 | Unsigned sample |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Trimmed mean; 0 when not valid |

## Verification
Start can coincide with two other events: the final sample of a burst, and the cycle in which a result is being presented.

The bench drives start together with the sixth sample. It expects no result pulse in the following cycle, and it expects a later result computed only from the samples of the new burst.

It also raises start in the EMIT cycle. It then checks both that the old result is presented intact and that the next six samples yield their own average.

// File: rtl/trim_avg_pkg.sv
package trim_avg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } tavg_state_e;
endpackage

// File: rtl/trim_avg_ctrl.sv
module trim_avg_ctrl
    import trim_avg_pkg::*;
#(
    parameter int SHORT_LEN = 6,
    parameter int LONG_LEN  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_i,
    input  logic smp_valid_i,
    output logic clr_o,
    output logic acc_en_o,
    output logic emit_o,
    output logic long_o
);
    localparam int CNT_W = $clog2(LONG_LEN);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_LEN - 1);

    tavg_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             long_q;
    logic             last_smp;

    assign last_smp = (cnt_q == (long_q ? LAST_L : LAST_S));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= '0;
            long_q <= long_i;
        end else if (acc_en_o) begin
            cnt_q  <= last_smp ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (start_i)                      state_d = ST_COLLECT;
                else if (smp_valid_i && last_smp) state_d = ST_EMIT;
            end
            ST_EMIT:    state_d = start_i ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clr_o    = start_i;
        acc_en_o = 1'b0;
        emit_o   = 1'b0;
        long_o   = long_q;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COLLECT: acc_en_o = smp_valid_i && !start_i;
            ST_EMIT:    emit_o   = 1'b1;
            default:    ;
        endcase
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |=> (state_q != ST_EMIT));
    a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_COLLECT) && (cnt_q == '0));
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (long_q ? LAST_L : LAST_S));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trim_avg_acc.sv
module trim_avg_acc #(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] max_o
);
    logic [SUM_W-1:0]  sum_q;
    logic [DATA_W-1:0] min_q, max_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            min_q <= '1;
            max_q <= '0;
        end else if (clr_i) begin
            sum_q <= '0;
            min_q <= '1;
            max_q <= '0;
        end else if (en_i) begin
            sum_q <= sum_q + SUM_W'(data_i);
            if (data_i < min_q) min_q <= data_i;
            if (data_i > max_q) max_q <= data_i;
        end
    end

    assign sum_o = sum_q;
    assign min_o = min_q;
    assign max_o = max_q;

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_q == '0) && (max_q == '0) && (min_q == '1));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> (sum_q >= $past(sum_q)));
    a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> (min_q <= max_q));
endmodule

// File: rtl/trim_avg_div.sv
module trim_avg_div #(
    parameter int DATA_W    = 12,
    parameter int SUM_W     = 16,
    parameter int SHORT_LEN = 6,
    parameter int LONG_LEN  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_i,
    input  logic              long_i,
    input  logic [SUM_W-1:0]  sum_i,
    input  logic [DATA_W-1:0] min_i,
    input  logic [DATA_W-1:0] max_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o
);
    localparam int SH_S = $clog2(SHORT_LEN - 2);
    localparam int SH_L = $clog2(LONG_LEN - 2);

    logic [SUM_W-1:0] trimmed, shifted;

    always_comb begin
        trimmed = sum_i - SUM_W'(min_i) - SUM_W'(max_i);
        shifted = long_i ? (trimmed >> SH_L) : (trimmed >> SH_S);
        res_valid_o = emit_i;
        res_data_o  = emit_i ? shifted[DATA_W-1:0] : '0;
    end

    a_r3_fits: assert property (@(posedge clk) disable iff (!rst_n)
        emit_i |-> (shifted[SUM_W-1:DATA_W] == '0));
endmodule

// File: rtl/trim_avg.sv
module trim_avg #(
    parameter int DATA_W    = 12,
    parameter int SHORT_LEN = 6,
    parameter int LONG_LEN  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              long_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o
);
    localparam int SUM_W = DATA_W + $clog2(LONG_LEN + 1);

    logic              clr, acc_en, emit, long_sel;
    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] min_v, max_v;

    trim_avg_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
        .smp_valid_i(smp_valid_i), .clr_o(clr), .acc_en_o(acc_en),
        .emit_o(emit), .long_o(long_sel)
    );

    trim_avg_acc #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(acc_en),
        .data_i(smp_data_i), .sum_o(sum), .min_o(min_v), .max_o(max_v)
    );

    trim_avg_div #(.DATA_W(DATA_W), .SUM_W(SUM_W),
                   .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_div (
        .clk(clk), .rst_n(rst_n), .emit_i(emit), .long_i(long_sel),
        .sum_i(sum), .min_i(min_v), .max_i(max_v),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o)
    );

    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_data_o >= min_v) && (res_data_o <= max_v));
    a_r1_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (res_data_o == '0));
endmodule

// File: tb/trim_avg_test.sv
`timescale 1ns/1ps
module trim_avg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, long_i = 1'b0, smp_valid_i = 1'b0;
    logic [11:0] smp_data_i = '0;
    logic        res_valid_o;
    logic [11:0] res_data_o;

    int checks = 0, errors = 0;
    bit done = 0;
    logic        got_v;
    logic [11:0] got_d;
    logic [11:0] buf_s [10];

    trim_avg uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o));

    always #2.5 clk = ~clk;

    task automatic step(input logic st, input logic lg, input logic v, input logic [11:0] d);
        @(negedge clk);
        got_v = res_valid_o;
        got_d = res_data_o;
        start_i = st; long_i = lg; smp_valid_i = v; smp_data_i = d;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [11:0] ed);
        checks++;
        if (got_v !== ev || got_d !== ed) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%03h expected valid=%0b data=%03h",
                     req, got_v, got_d, ev, ed);
        end
    endtask

    function automatic logic [11:0] model(input int n);
        int s = 0, mn = 4095, mx = 0;
        for (int i = 0; i < n; i++) begin
            s += buf_s[i];
            if (buf_s[i] < mn) mn = buf_s[i];
            if (buf_s[i] > mx) mx = buf_s[i];
        end
        return 12'((s - mn - mx) / (n - 2));
    endfunction

    task automatic feed(input int n, input logic lg);
        for (int i = 0; i < n; i++) step(1'b0, lg, 1'b1, buf_s[i]);
    endtask

    task automatic t_reset;
        step(0, 0, 0, 0);
        expect_out("R1 reset state", 1'b0, 12'h000);
        for (int i = 0; i < 10; i++) buf_s[i] = 12'h111;
        feed(10, 1'b0);
        step(0, 0, 0, 0);
        expect_out("R1 no result before start", 1'b0, 12'h000);
    endtask

    task automatic t_short;
        for (int i = 0; i < 6; i++) buf_s[i] = 12'((i + 1) * 100);
        step(1, 0, 0, 0);
        feed(6, 0);
        step(0, 0, 0, 0);
        expect_out("R4 six-sample mean", 1'b1, 12'd350);
        step(0, 0, 0, 0);
        expect_out("R7 one-cycle pulse", 1'b0, 12'h000);
    endtask

    task automatic t_full_scale;
        for (int i = 0; i < 10; i++) buf_s[i] = 12'hFFF;
        step(1, 1, 0, 0);
        feed(6, 1);
        step(0, 1, 0, 0);
        expect_out("R2 long burst not done at six", 1'b0, 12'h000);
        for (int i = 6; i < 10; i++) step(0, 1, 1, buf_s[i]);
        step(0, 0, 0, 0);
        expect_out("R3 full-scale ten", 1'b1, 12'hFFF);
    endtask

    task automatic t_truncate;
        for (int i = 0; i < 10; i++) buf_s[i] = 12'(i + 1);
        step(1, 1, 0, 0);
        feed(10, 1);
        step(0, 0, 0, 0);
        expect_out("R5 ten-sample truncation", 1'b1, 12'd5);
    endtask

    task automatic t_dups;
        buf_s[0] = 5; buf_s[1] = 9; buf_s[2] = 5; buf_s[3] = 9; buf_s[4] = 5; buf_s[5] = 9;
        step(1, 0, 0, 0);
        feed(6, 0);
        step(0, 0, 0, 0);
        expect_out("R6 duplicate extremes", 1'b1, 12'd7);
    endtask

    task automatic t_gaps_latch;
        buf_s[0] = 12'h800; buf_s[1] = 12'h010; buf_s[2] = 12'h7F0;
        buf_s[3] = 12'hABC; buf_s[4] = 12'h333; buf_s[5] = 12'h444;
        step(1, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            step(0, 1, 1, buf_s[i]);
            step(0, 1, 0, 12'hFFF);
            if (i < 5) expect_out("R10 gap cycles do not count", 1'b0, 12'h000);
        end
        expect_out("R2 length latched at start", 1'b1, model(6));
    endtask

    task automatic t_restart;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 1, 12'hFFF); step(0, 0, 1, 12'h000); step(0, 0, 1, 12'hFFF);
        for (int i = 0; i < 6; i++) buf_s[i] = 12'(40 + 8 * i);
        step(1, 0, 0, 0);
        feed(6, 0);
        step(0, 0, 0, 0);
        expect_out("R8 restart abandons partial burst", 1'b1, model(6));
    endtask

    task automatic t_start_final;
        step(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 12'h100);
        step(1, 0, 1, 12'hFFF);
        step(0, 0, 0, 0);
        expect_out("R9 start beats final sample", 1'b0, 12'h000);
        buf_s[0] = 2; buf_s[1] = 30; buf_s[2] = 31; buf_s[3] = 32; buf_s[4] = 33; buf_s[5] = 900;
        feed(6, 0);
        step(0, 0, 0, 0);
        expect_out("R9 fresh burst after start", 1'b1, model(6));
    endtask

    task automatic t_start_emit;
        for (int i = 0; i < 6; i++) buf_s[i] = 12'(200 + i);
        step(1, 0, 0, 0);
        feed(6, 0);
        step(1, 0, 0, 0);
        expect_out("R11 result kept with start", 1'b1, model(6));
        for (int i = 0; i < 6; i++) buf_s[i] = 12'(1000 - 50 * i);
        feed(6, 0);
        step(0, 0, 0, 0);
        expect_out("R11 new burst after start", 1'b1, model(6));
    endtask

    task automatic t_after_result;
        for (int i = 0; i < 6; i++) step(0, 0, 1, 12'h555);
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 0);
            expect_out("R10 samples after result ignored", 1'b0, 12'h000);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_short();
        t_full_scale();
        t_truncate();
        t_dups();
        t_gaps_latch();
        t_restart();
        t_start_final();
        t_start_emit();
        t_after_result();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule